// File: doc/BRIEF.md
# Conversion Sequencer with Settling Control

This block sits between the decimation filter of a delta-sigma converter and whatever reads its results. It counts master clocks to mark the end of each conversion period. The period is either a slow or a fast length, chosen by a rate select input. At each period end it decides whether the filter output counts as a valid result. After reset it runs conversions continuously, and the first strobe marks the end of the first conversion.

The channel, gain and rate selects are registered and compared with the setting last put into effect. A difference opens a setup window. When the window closes, the newest setting takes effect, a one-cycle chain reset clears the modulator and the filter, and result strobes are withheld until four full periods have passed. Further changes inside the window are merged into that one reset. A change that arrives while the filter is settling restarts the settling. When the overrange flag is high at a period end that would produce a result, the word is clipped to full scale in the direction of the raw sign and the chain is reset. A held overrange therefore gives results at one quarter of the normal rate.

Top module: `conv_seq`

## Requirements
- R1: While reset is held, `valid_o`, `chain_rst_o` and `word_o` are all zero. After reset is released with the rate select high, the first `valid_o` pulse arrives exactly `FAST_CYC` cycles after the release.
- R2: With the fast rate in effect and no overrange, `valid_o` is a one-cycle pulse that repeats every `FAST_CYC` cycles.
- R3: With the slow rate (`rate_i`=0) in effect, the first pulse comes 4·`SLOW_CYC` cycles after the chain reset, and later pulses come every `SLOW_CYC` cycles.
- R4: A change on any select input is acted on after the setup window. `chain_rst_o` pulses for exactly one cycle, `SETUP_CYC`+2 cycles after the new value is presented ahead of a rising edge.
- R5: Several select changes inside one setup window produce exactly one `chain_rst_o` pulse.
- R6: After a chain reset caused by a select change, no `valid_o` is issued until exactly `SETTLE_CNT`·P cycles later, where P is the period length in effect (`SETTLE_CNT`=4 by default).
- R7: A select change that takes effect while settling is in progress restarts the full settling count from its own chain reset.
- R8: Without overrange, `word_o` takes the 24-bit two's complement raw word on each `valid_o` and holds it until the next one (zero is 000000, minus one LSB is FFFFFF).
- R9: When `ovr_i` is high at a result-producing period end, `word_o` becomes 7FFFFF if raw bit 23 is 0, or 800000 if it is 1. `chain_rst_o` pulses in the same cycle as that `valid_o`.
- R10: While `ovr_i` stays high, `valid_o` pulses every 4·P cycles, one quarter of the normal rate.
- R11: When a select change takes effect on the very cycle a period would complete, the chain reset wins: no `valid_o` is issued in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master conversion clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-down) |
| chan_i | input | CH_W | Channel select |
| gain_i | input | GAIN_W | Gain select |
| rate_i | input | 1 | Rate select: 1 fast, 0 slow |
| ovr_i | input | 1 | Overrange flag from the modulator |
| raw_i | input | 24 | Raw filter output, two's complement |
| chain_rst_o | output | 1 | One-cycle reset to modulator and filter |
| valid_o | output | 1 | Result-valid strobe |
| word_o | output | 24 | Result word, clipped on overrange |

## Verification
Two events can fall on the same clock edge: a select change taking effect, and a conversion period completing with a result due. The bench times a channel change from a known strobe, so that the end of the setup window falls exactly on the next period end. At that cycle it requires `chain_rst_o` high and `valid_o` low, and the next strobe only a full settling interval later. The overrange clip and its restart also share a cycle with the strobe, and the bench judges that pairing from the port values of the clipped word.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  localparam int WORD_W = 24;
  typedef logic [WORD_W-1:0] word_t;
  localparam word_t POS_FS = {1'b0, {(WORD_W-1){1'b1}}};
  localparam word_t NEG_FS = {1'b1, {(WORD_W-1){1'b0}}};

  function automatic word_t clip_fs(input word_t raw);
    return raw[WORD_W-1] ? NEG_FS : POS_FS;
  endfunction
endpackage

// File: rtl/cseq_sel_track.sv
module cseq_sel_track #(
  parameter int SEL_W     = 5,
  parameter int SETUP_CYC = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             apply_o,
  output logic             fast_o
);
  localparam int CW = $clog2(SETUP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETUP_CYC - 1);

  logic [SEL_W-1:0] sel_q, applied_q;
  logic             init_q, pending_q;
  logic [CW-1:0]    cnt_q;

  assign apply_o = pending_q && (cnt_q == LAST);
  assign fast_o  = applied_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= '0;
      applied_q <= '0;
      init_q    <= 1'b0;
      pending_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      sel_q <= sel_i;
      if (!init_q) begin
        // first sample after power-up is taken as-is, no restart
        init_q    <= 1'b1;
        applied_q <= sel_i;
      end else if (apply_o) begin
        applied_q <= sel_q;
        pending_q <= 1'b0;
      end else if (pending_q) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (sel_q != applied_q) begin
        pending_q <= 1'b1;
        cnt_q     <= '0;
      end
    end
  end
endmodule

// File: rtl/cseq_period_timer.sv
module cseq_period_timer #(
  parameter int SLOW_CYC = 491520,
  parameter int FAST_CYC = 61440
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic fast_i,
  output logic end_o
);
  localparam int CNT_W = $clog2(SLOW_CYC + 1);
  localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_CYC - 1);
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign end_o = (cnt_q == (fast_i ? FAST_LIM : SLOW_LIM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i || end_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cseq_settle_ctrl.sv
module cseq_settle_ctrl
  import cseq_pkg::*;
#(
  parameter int SETTLE_CNT = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  apply_i,
  input  logic  end_i,
  input  logic  ovr_i,
  input  word_t raw_i,
  output logic  valid_o,
  output logic  ovr_rst_o,
  output word_t word_o
);
  localparam int LW = $clog2(SETTLE_CNT + 1);
  localparam logic [LW-1:0] HIDE = LW'(SETTLE_CNT - 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q    <= '0;
      valid_o   <= 1'b0;
      ovr_rst_o <= 1'b0;
      word_o    <= '0;
    end else begin
      valid_o   <= 1'b0;
      ovr_rst_o <= 1'b0;
      if (apply_i) begin
        left_q <= HIDE;               // restart wins over a period end
      end else if (end_i) begin
        if (left_q != '0) begin
          left_q <= left_q - 1'b1;
        end else begin
          valid_o <= 1'b1;
          if (ovr_i) begin
            word_o    <= clip_fs(raw_i);
            ovr_rst_o <= 1'b1;
            left_q    <= HIDE;
          end else begin
            word_o <= raw_i;
          end
        end
      end
    end
  end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import cseq_pkg::*;
#(
  parameter int SLOW_CYC   = 491520,
  parameter int FAST_CYC   = 61440,
  parameter int SETUP_CYC  = 220,
  parameter int SETTLE_CNT = 4,
  parameter int CH_W       = 2,
  parameter int GAIN_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              rate_i,
  input  logic              ovr_i,
  input  logic [23:0]       raw_i,
  output logic              chain_rst_o,
  output logic              valid_o,
  output logic [23:0]       word_o
);
  localparam int SEL_W = CH_W + GAIN_W + 1;

  logic apply, fast, per_end, ovr_rst, apply_q;

  cseq_sel_track #(.SEL_W(SEL_W), .SETUP_CYC(SETUP_CYC)) i_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  ({chan_i, gain_i, rate_i}),
    .apply_o(apply),
    .fast_o (fast)
  );

  cseq_period_timer #(.SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC)) i_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(apply),
    .fast_i   (fast),
    .end_o    (per_end)
  );

  cseq_settle_ctrl #(.SETTLE_CNT(SETTLE_CNT)) i_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .apply_i  (apply),
    .end_i    (per_end),
    .ovr_i    (ovr_i),
    .raw_i    (raw_i),
    .valid_o  (valid_o),
    .ovr_rst_o(ovr_rst),
    .word_o   (word_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) apply_q <= 1'b0;
    else         apply_q <= apply;
  end

  assign chain_rst_o = apply_q | ovr_rst;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int SETTLE_CNT = 4,
  parameter int FAST_CYC   = 61440
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_o,
  input logic        chain_rst_o,
  input logic [23:0] word_o
);
  logic [31:0] since_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (chain_rst_o) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != 32'hFFFF_FFFF) begin
      since_q <= since_q + 1'b1;
    end
  end

  assert_strobe_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_rst_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_rst_o |=> !chain_rst_o);

  assert_no_early_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seen_q) |-> (since_q >= 32'(SETTLE_CNT * FAST_CYC - 1)));

  assert_hold_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));

  assert_clip_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && chain_rst_o) |-> (word_o == 24'h7FFFFF || word_o == 24'h800000));

  assert_hidden_after_rst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_rst_o && !valid_o) |=> !valid_o);
endmodule

bind conv_seq conv_seq_chk #(.SETTLE_CNT(SETTLE_CNT), .FAST_CYC(FAST_CYC)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_o    (valid_o),
  .chain_rst_o(chain_rst_o),
  .word_o     (word_o)
);

// File: tb/test_conv_seq.sv
module test_conv_seq;
  localparam int F  = 20;
  localparam int SL = 48;
  localparam int S  = 5;
  localparam int N  = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  chan_i = '0;
  logic [1:0]  gain_i = '0;
  logic        rate_i = 1'b1;
  logic        ovr_i = 1'b0;
  logic [23:0] raw_i = 24'h123456;
  logic        chain_rst_o, valid_o;
  logic [23:0] word_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  conv_seq #(.SLOW_CYC(SL), .FAST_CYC(F), .SETUP_CYC(S), .SETTLE_CNT(N)) i_conv_seq (
    .clk_i, .rst_ni, .chan_i, .gain_i, .rate_i, .ovr_i, .raw_i,
    .chain_rst_o, .valid_o, .word_o
  );

  typedef struct packed {
    logic [23:0] raw;
    logic        ovr;
    logic [23:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{24'h000000, 1'b0, 24'h000000},
    '{24'hFFFFFF, 1'b0, 24'hFFFFFF},
    '{24'h7FFFFF, 1'b0, 24'h7FFFFF},
    '{24'h800000, 1'b0, 24'h800000},
    '{24'h400000, 1'b1, 24'h7FFFFF},
    '{24'hC00001, 1'b1, 24'h800000}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!valid_o && n < 8 * SL);
  endtask

  task automatic wait_rst(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!chain_rst_o && n < 8 * SL);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int pulses;
    idle(3);
    // R1 reset state
    check(!valid_o && !chain_rst_o && word_o == 0, "R1 reset", {valid_o, chain_rst_o}, 0);
    rst_ni = 1'b1;
    wait_valid(n);
    check(n == F, "R1 first ready", n, F);
    check(word_o == 24'h123456, "R8 first word", word_o, 24'h123456);
    wait_valid(n);
    check(n == F, "R2 period", n, F);

    // table walk: R8 pass-through, R9 clip
    for (int v = 0; v < 6; v++) begin
      raw_i = VECS[v].raw;
      ovr_i = VECS[v].ovr;
      wait_valid(n);
      check(word_o == VECS[v].exp, VECS[v].ovr ? "R9 clip" : "R8 word", word_o, VECS[v].exp);
      if (VECS[v].ovr) check(chain_rst_o, "R9 restart", chain_rst_o, 1);
    end
    // R10 quarter rate under held overrange
    wait_valid(n);
    check(n == N * F, "R10 quarter rate", n, N * F);
    ovr_i = 1'b0; raw_i = 24'h0000AA;
    wait_valid(n);
    wait_valid(n);
    check(n == F, "R2 rate restored", n, F);

    // R4 / R6 channel change
    chan_i = 2'd1;
    wait_rst(n);
    check(n == S + 2, "R4 setup delay", n, S + 2);
    @(negedge clk_i);
    check(!chain_rst_o, "R4 one cycle", chain_rst_o, 0);
    wait_valid(n);
    check(n == N * F - 1, "R6 settle", n + 1, N * F);

    // R5 merged changes
    gain_i = 2'd1;
    idle(2);
    gain_i = 2'd2;
    pulses = 0;
    for (int i = 0; i < S + N * F + 6; i++) begin
      @(negedge clk_i);
      if (chain_rst_o) pulses++;
    end
    check(pulses == 1, "R5 single reset", pulses, 1);

    // R7 restart during settling
    chan_i = 2'd2;
    wait_rst(n);
    pulses = 0;
    for (int i = 0; i < 2 * F; i++) begin
      @(negedge clk_i);
      if (valid_o) pulses++;
    end
    check(pulses == 0, "R7 hidden while settling", pulses, 0);
    chan_i = 2'd3;
    wait_rst(n);
    check(n == S + 2, "R7 second reset", n, S + 2);
    wait_valid(n);
    check(n == N * F, "R7 full resettle", n, N * F);

    // R3 slow rate
    rate_i = 1'b0;
    wait_rst(n);
    wait_valid(n);
    check(n == N * SL, "R3 slow settle", n, N * SL);
    wait_valid(n);
    check(n == SL, "R3 slow period", n, SL);

    // R11 reset lands on a period end
    rate_i = 1'b1;
    wait_rst(n);
    wait_valid(n);
    idle(F - S - 2);
    chan_i = 2'd0;
    idle(S + 2);
    check(chain_rst_o && !valid_o, "R11 restart wins", {chain_rst_o, valid_o}, 2);
    wait_valid(n);
    check(n == N * F, "R11 next ready", n, N * F);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule